// File: doc/BRIEF.md
# Memory-Destination Byte-Add Decoder

This block takes in the instruction stream of a byte add, one 16-bit word per cycle. The destination of the add may be a register or a memory operand, and the source is either an 8-bit immediate or a byte register. A variable number of words describes one instruction: prefix words, a mode word, displacement or absolute-address extension words, and an operand word. The decoder follows each word sequence through a small state machine. It gathers the extension words into one 32-bit field and presents a single decoded record, which is held until a downstream stage accepts it.

The record gives the destination addressing mode, the base register index, the source kind, the source register index or immediate value, the count of extension words, and the extension data. A word sequence that fits no supported pattern raises a one-cycle illegal flag. The decoder then starts again at a first word. While a record is pending, no input word is taken.

Top module: `badd_dec_top`

## Requirements
- R1: `in_ready` is low whenever `out_valid` is high. A pending record holds every field stable until a cycle with `out_ready` high clears `out_valid`. A word offered while the record is pending is not consumed. `out_valid` rises in the cycle after the last word of an instruction is accepted.
- R2: Register-direct forms complete in one word and report mode 0. A word with 0x08 in bits 15:8 gives source register bits 7:4 and base register bits 3:0, with `src_is_reg`=1. A word with 0x8 in bits 15:12 gives base register bits 11:8 and immediate bits 7:0, with `src_is_reg`=0.
- R3: A first word with 0x7D in bits 15:8 selects register-indirect, mode 1, with base in bits 7:4. The operand word that follows is either an immediate word (bits 15:12 = 0x8, value in bits 7:0) or a register word (bits 15:8 = 0x08, source in bits 7:4).
- R4: The first words 0x0174, 0x0176, 0x0175 and 0x0177 select post-increment (mode 2), post-decrement (mode 3), pre-increment (mode 4) and pre-decrement (mode 5) with an immediate source. They must be followed by a word with 0x6C in bits 15:8, base in bits 7:4 and 0x8 in bits 3:0, and then an immediate word.
- R5: 0x0174 followed by a word with 0x6E in bits 15:8 and 0x8 in bits 3:0 selects 16-bit displacement, mode 6, with base in bits 7:4. One displacement word follows, then the immediate word.
- R6: A first word with 0x78 in bits 15:8 and bit 7 clear selects 32-bit displacement, mode 7, with base in bits 6:4. It must be followed by 0x6A28, then two displacement words, then the immediate word.
- R7: A first word with 0x7F in bits 15:8 selects 8-bit absolute, mode 8, with the address in bits 7:0. A first word with 0x6A1 in bits 15:4 selects 16-bit absolute, mode 9, with one address word. A first word with 0x6A3 in bits 15:4 selects 32-bit absolute, mode 10, with two address words. Each is then followed by an immediate or register operand word, and the base reads 0.
- R8: After the first word 0x0179, a mode word carries the mode in bits 15:12 (0x8 = mode 2, 0xA = mode 3, 0x9 = mode 4, 0xB = mode 5, 0xC = mode 6 with one displacement word, 0xD = mode 7 with two), the base in bits 10:8, the value 1 in bits 7:4 and the source register in bits 3:0. Displacement words follow it directly, and no operand word comes after them.
- R9: A word that does not fit the pattern expected at its position is consumed. `illegal` goes high for exactly the next cycle, no record is produced, and the next word is decoded as a first word.
- R10: `ext_words` is 0 for modes 0 to 5 and 8, 1 for modes 6 and 9, and 2 for modes 7 and 10. `ext_data` holds the first extension word in bits 31:16 and the second in bits 15:0 for two words, the single word in bits 15:0 for one word, the address zero-extended for mode 8, and 0 otherwise.
- R11: After reset, `out_valid` and `illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 16 | Instruction word |
| in_ready | output | 1 | Decoder can take a word |
| out_valid | output | 1 | Decoded record pending |
| out_ready | input | 1 | Consumer takes the record |
| dst_mode | output | 4 | Destination mode code (0 to 10) |
| base_reg | output | 4 | Base or destination register index |
| src_is_reg | output | 1 | 1 = register source, 0 = immediate |
| src_val | output | 8 | Source register index or immediate |
| ext_words | output | 2 | Count of extension words |
| ext_data | output | 32 | Displacement or absolute address |
| illegal | output | 1 | One-cycle flag for an unmatched sequence |

## Verification
A state machine stuck in the wrong position shows up at the ports within a word or two. Either a legal continuation word raises `illegal`, or a record appears with the wrong mode or too few words. An extension counter or shift register that is off by one shows as a wrong `ext_data` value or a record that arrives one word early or late. A mis-held record shows as fields that change while `out_valid` stays high and `out_ready` is low, which is visible in the very next cycle.

// File: rtl/badd_dec_pkg.sv
package badd_dec_pkg;
  localparam int WORD_W  = 16;
  localparam int MAX_EXT = 2;
  localparam int EXT_W   = WORD_W * MAX_EXT;
  localparam int CNT_W   = $clog2(MAX_EXT + 1);
  localparam int REG_W   = 4;
  localparam int SRC_W   = 8;

  typedef enum logic [3:0] {
    MD_REG     = 4'd0,
    MD_IND     = 4'd1,
    MD_POSTINC = 4'd2,
    MD_POSTDEC = 4'd3,
    MD_PREINC  = 4'd4,
    MD_PREDEC  = 4'd5,
    MD_DISP16  = 4'd6,
    MD_DISP32  = 4'd7,
    MD_ABS8    = 4'd8,
    MD_ABS16   = 4'd9,
    MD_ABS32   = 4'd10
  } mode_t;

  typedef enum logic [2:0] {
    ST_FIRST, ST_AUTO, ST_R79, ST_X78, ST_EXT, ST_OPND
  } st_t;

  typedef struct packed {
    logic             bad;
    logic             done;
    st_t              nxt;
    logic             set_mode;
    mode_t            mode;
    logic             set_base;
    logic [REG_W-1:0] base;
    logic             set_src;
    logic             src_reg;
    logic [SRC_W-1:0] src;
    logic [CNT_W-1:0] ext_n;
    logic             need_opnd;
  } step_t;

  function automatic step_t f_idle_step();
    step_t s;
    s = '0;
    s.nxt = ST_FIRST;
    return s;
  endfunction

  // number of extension words implied by a destination mode
  function automatic logic [CNT_W-1:0] f_ext_words(mode_t m);
    case (m)
      MD_DISP16, MD_ABS16: return CNT_W'(1);
      MD_DISP32, MD_ABS32: return CNT_W'(2);
      default:             return CNT_W'(0);
    endcase
  endfunction

  // auto-modify mode from the low nibble of an immediate-source prefix
  function automatic mode_t f_auto_mode(logic [3:0] nib);
    case (nib)
      4'h4:    return MD_POSTINC;
      4'h6:    return MD_POSTDEC;
      4'h5:    return MD_PREINC;
      default: return MD_PREDEC;
    endcase
  endfunction

  // register-source mode nibble; bit 4 of result is the valid flag
  function automatic logic [4:0] f_r79_mode(logic [3:0] nib);
    case (nib)
      4'h8:    return {1'b1, MD_POSTINC};
      4'hA:    return {1'b1, MD_POSTDEC};
      4'h9:    return {1'b1, MD_PREINC};
      4'hB:    return {1'b1, MD_PREDEC};
      4'hC:    return {1'b1, MD_DISP16};
      4'hD:    return {1'b1, MD_DISP32};
      default: return {1'b0, MD_REG};
    endcase
  endfunction

  // final operand word: immediate or byte register
  function automatic step_t f_opnd_step(logic [WORD_W-1:0] w);
    step_t s;
    s = f_idle_step();
    if (w[15:12] == 4'h8) begin
      s.set_src = 1'b1;
      s.src_reg = 1'b0;
      s.src     = w[7:0];
      s.done    = 1'b1;
    end else if (w[15:8] == 8'h08) begin
      s.set_src = 1'b1;
      s.src_reg = 1'b1;
      s.src     = {4'h0, w[7:4]};
      s.done    = 1'b1;
    end else begin
      s.bad = 1'b1;
    end
    return s;
  endfunction
endpackage

// File: rtl/badd_first_dec.sv
module badd_first_dec
  import badd_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output step_t             step,
  output logic [EXT_W-1:0]  ext_seed
);
  always_comb begin
    step          = f_idle_step();
    step.set_mode = 1'b1;
    step.set_base = 1'b1;
    step.mode     = MD_REG;
    step.base     = '0;
    ext_seed      = '0;
    if (word[15:8] == 8'h08) begin
      step.base    = word[3:0];
      step.set_src = 1'b1;
      step.src_reg = 1'b1;
      step.src     = {4'h0, word[7:4]};
      step.done    = 1'b1;
    end else if (word[15:12] == 4'h8) begin
      step.base    = word[11:8];
      step.set_src = 1'b1;
      step.src_reg = 1'b0;
      step.src     = word[7:0];
      step.done    = 1'b1;
    end else if (word[15:8] == 8'h7D) begin
      step.mode = MD_IND;
      step.base = word[7:4];
      step.nxt  = ST_OPND;
    end else if (word[15:4] == 12'h017 && word[3:0] inside {4'h4, 4'h5, 4'h6, 4'h7}) begin
      step.mode = f_auto_mode(word[3:0]);
      step.nxt  = ST_AUTO;
    end else if (word == 16'h0179) begin
      step.nxt = ST_R79;
    end else if (word[15:8] == 8'h78 && !word[7]) begin
      step.mode = MD_DISP32;
      step.base = {1'b0, word[6:4]};
      step.nxt  = ST_X78;
    end else if (word[15:8] == 8'h7F) begin
      step.mode = MD_ABS8;
      ext_seed  = EXT_W'(word[7:0]);
      step.nxt  = ST_OPND;
    end else if (word[15:4] == 12'h6A1) begin
      step.mode      = MD_ABS16;
      step.ext_n     = f_ext_words(MD_ABS16);
      step.need_opnd = 1'b1;
      step.nxt       = ST_EXT;
    end else if (word[15:4] == 12'h6A3) begin
      step.mode      = MD_ABS32;
      step.ext_n     = f_ext_words(MD_ABS32);
      step.need_opnd = 1'b1;
      step.nxt       = ST_EXT;
    end else begin
      step     = f_idle_step();
      step.bad = 1'b1;
    end
  end
endmodule

// File: rtl/badd_follow_dec.sv
module badd_follow_dec
  import badd_dec_pkg::*;
(
  input  st_t               state,
  input  mode_t             cur_mode,
  input  logic [WORD_W-1:0] word,
  output step_t             step
);
  logic [4:0] r79;

  always_comb begin
    r79  = f_r79_mode(word[15:12]);
    step = f_idle_step();
    case (state)
      ST_AUTO: begin
        if (word[15:8] == 8'h6C && word[3:0] == 4'h8) begin
          step.set_base = 1'b1;
          step.base     = word[7:4];
          step.nxt      = ST_OPND;
        end else if (word[15:8] == 8'h6E && word[3:0] == 4'h8 && cur_mode == MD_POSTINC) begin
          step.set_mode  = 1'b1;
          step.mode      = MD_DISP16;
          step.set_base  = 1'b1;
          step.base      = word[7:4];
          step.ext_n     = f_ext_words(MD_DISP16);
          step.need_opnd = 1'b1;
          step.nxt       = ST_EXT;
        end else begin
          step.bad = 1'b1;
        end
      end
      ST_R79: begin
        if (r79[4] && word[7:4] == 4'h1) begin
          step.set_mode = 1'b1;
          step.mode     = mode_t'(r79[3:0]);
          step.set_base = 1'b1;
          step.base     = {1'b0, word[10:8]};
          step.set_src  = 1'b1;
          step.src_reg  = 1'b1;
          step.src      = {4'h0, word[3:0]};
          step.ext_n    = f_ext_words(mode_t'(r79[3:0]));
          if (step.ext_n == '0) step.done = 1'b1;
          else                  step.nxt  = ST_EXT;
        end else begin
          step.bad = 1'b1;
        end
      end
      ST_X78: begin
        if (word == 16'h6A28) begin
          step.ext_n     = f_ext_words(MD_DISP32);
          step.need_opnd = 1'b1;
          step.nxt       = ST_EXT;
        end else begin
          step.bad = 1'b1;
        end
      end
      ST_OPND: step = f_opnd_step(word);
      default: step = f_idle_step();
    endcase
  end
endmodule

// File: rtl/badd_ext_shift.sv
module badd_ext_shift
  import badd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [EXT_W-1:0]  clear_val,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_n,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word,
  output logic [EXT_W-1:0]  ext,
  output logic              last
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext  <= '0;
      left <= '0;
    end else begin
      if (clear)   ext  <= clear_val;
      if (load_en) left <= load_n;
      if (shift_en) begin
        ext  <= {ext[EXT_W-WORD_W-1:0], word};
        left <= left - CNT_W'(1);
      end
    end
  end

  assign last = (left == CNT_W'(1));
endmodule

// File: rtl/badd_dec_top.sv
module badd_dec_top
  import badd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        dst_mode,
  output logic [REG_W-1:0]  base_reg,
  output logic              src_is_reg,
  output logic [SRC_W-1:0]  src_val,
  output logic [CNT_W-1:0]  ext_words,
  output logic [EXT_W-1:0]  ext_data,
  output logic              illegal
);
  st_t              state;
  mode_t            r_mode;
  logic             r_need_opnd;
  step_t            first_step, follow_step, step;
  logic [EXT_W-1:0] ext_seed;
  logic             ext_last;

  // named events for the checker
  logic word_acc, bad_acc, rec_finish, in_ext;

  assign in_ready = !out_valid;
  assign word_acc = in_valid && in_ready;
  assign in_ext   = (state == ST_EXT);
  assign step     = (state == ST_FIRST) ? first_step : follow_step;
  assign bad_acc  = word_acc && !in_ext && step.bad;
  assign rec_finish = word_acc && (in_ext ? (ext_last && !r_need_opnd) : (!step.bad && step.done));

  badd_first_dec u_first (
    .word     (in_word),
    .step     (first_step),
    .ext_seed (ext_seed)
  );

  badd_follow_dec u_follow (
    .state    (state),
    .cur_mode (r_mode),
    .word     (in_word),
    .step     (follow_step)
  );

  badd_ext_shift u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (word_acc && state == ST_FIRST),
    .clear_val (ext_seed),
    .load_en   (word_acc && !in_ext && !step.bad && step.ext_n != '0),
    .load_n    (step.ext_n),
    .shift_en  (word_acc && in_ext),
    .word      (in_word),
    .ext       (ext_data),
    .last      (ext_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_FIRST;
      out_valid   <= 1'b0;
      illegal     <= 1'b0;
      r_mode      <= MD_REG;
      base_reg    <= '0;
      src_is_reg  <= 1'b0;
      src_val     <= '0;
      ext_words   <= '0;
      r_need_opnd <= 1'b0;
    end else begin
      illegal <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (word_acc) begin
        if (in_ext) begin
          if (ext_last) begin
            if (r_need_opnd) state <= ST_OPND;
            else begin
              out_valid <= 1'b1;
              state     <= ST_FIRST;
            end
          end
        end else if (step.bad) begin
          illegal <= 1'b1;
          state   <= ST_FIRST;
        end else begin
          if (step.set_mode) r_mode   <= step.mode;
          if (step.set_base) base_reg <= step.base;
          if (step.set_src) begin
            src_is_reg <= step.src_reg;
            src_val    <= step.src;
          end
          if (state == ST_FIRST || step.ext_n != '0) begin
            ext_words   <= step.ext_n;
            r_need_opnd <= step.need_opnd;
          end
          if (step.done) begin
            out_valid <= 1'b1;
            state     <= ST_FIRST;
          end else begin
            state <= step.nxt;
          end
        end
      end
    end
  end

  assign dst_mode = r_mode;
endmodule

// File: rtl/badd_dec_chk.sv
module badd_dec_chk
  import badd_dec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       dst_mode,
  input logic [REG_W-1:0] base_reg,
  input logic             src_is_reg,
  input logic [SRC_W-1:0] src_val,
  input logic [CNT_W-1:0] ext_words,
  input logic [EXT_W-1:0] ext_data,
  input logic             illegal,
  input logic             word_acc,
  input logic             bad_acc,
  input logic             rec_finish
);
  AST_PENDING_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({dst_mode, base_reg, src_is_reg, src_val, ext_words, ext_data}))); // R1
  AST_FINISH_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rec_finish |=> out_valid); // R1
  AST_BAD_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> (illegal && !out_valid)); // R9
  AST_PULSE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(word_acc)); // R9
  AST_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dst_mode <= 4'd10)); // R2
  AST_EXT_COUNT_BY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ext_words == ((dst_mode == 4'd6 || dst_mode == 4'd9) ? 2'd1 :
                                 (dst_mode == 4'd7 || dst_mode == 4'd10) ? 2'd2 : 2'd0))); // R10
  AST_REG_SRC_IS_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && src_is_reg) |-> (src_val[7:4] == 4'h0)); // R8
endmodule

bind badd_dec_top badd_dec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .dst_mode   (dst_mode),
  .base_reg   (base_reg),
  .src_is_reg (src_is_reg),
  .src_val    (src_val),
  .ext_words  (ext_words),
  .ext_data   (ext_data),
  .illegal    (illegal),
  .word_acc   (word_acc),
  .bad_acc    (bad_acc),
  .rec_finish (rec_finish)
);

// File: tb/badd_dec_top_tb.sv
module badd_dec_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  dst_mode;
  logic [3:0]  base_reg;
  logic        src_is_reg;
  logic [7:0]  src_val;
  logic [1:0]  ext_words;
  logic [31:0] ext_data;
  logic        illegal;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  badd_dec_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .dst_mode(dst_mode), .base_reg(base_reg), .src_is_reg(src_is_reg),
    .src_val(src_val), .ext_words(ext_words), .ext_data(ext_data),
    .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] rec(input logic [3:0] m, input logic [3:0] b, input logic r,
                                      input logic [7:0] s, input logic [1:0] n, input logic [31:0] e);
    return {13'd0, m, b, r, s, n, e};
  endfunction

  task automatic expect_rec(input string tag, input logic [3:0] m, input logic [3:0] b, input logic r,
                            input logic [7:0] s, input logic [1:0] n, input logic [31:0] e);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(tag, rec(dst_mode, base_reg, src_is_reg, src_val, ext_words, ext_data), rec(m, b, r, s, n, e));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset", {61'd0, out_valid, illegal, in_ready}, 64'b001);
  endtask

  task automatic t_direct;
    send(16'h0835); expect_rec("R2 reg-reg", 4'd0, 4'h5, 1'b1, 8'h03, 2'd0, 32'h0);
    send(16'h8A7F); expect_rec("R2 imm-reg", 4'd0, 4'hA, 1'b0, 8'h7F, 2'd0, 32'h0);
  endtask

  task automatic t_indirect;
    send(16'h7D30); send(16'h8005); expect_rec("R3 ind imm", 4'd1, 4'h3, 1'b0, 8'h05, 2'd0, 32'h0);
    send(16'h7D60); send(16'h0890); expect_rec("R3 ind reg", 4'd1, 4'h6, 1'b1, 8'h09, 2'd0, 32'h0);
  endtask

  task automatic t_auto_imm;
    send(16'h0174); send(16'h6C28); send(16'h8011); expect_rec("R4 postinc", 4'd2, 4'h2, 1'b0, 8'h11, 2'd0, 32'h0);
    send(16'h0176); send(16'h6C38); send(16'h8022); expect_rec("R4 postdec", 4'd3, 4'h3, 1'b0, 8'h22, 2'd0, 32'h0);
    send(16'h0175); send(16'h6C48); send(16'h8033); expect_rec("R4 preinc",  4'd4, 4'h4, 1'b0, 8'h33, 2'd0, 32'h0);
    send(16'h0177); send(16'h6C58); send(16'h8044); expect_rec("R4 predec",  4'd5, 4'h5, 1'b0, 8'h44, 2'd0, 32'h0);
  endtask

  task automatic t_disp_imm;
    send(16'h0174); send(16'h6E48); send(16'hFFFF); send(16'h8005);
    expect_rec("R5 disp16 imm", 4'd6, 4'h4, 1'b0, 8'h05, 2'd1, 32'h0000FFFF);
    send(16'h7850); send(16'h6A28); send(16'h1234); send(16'h5678); send(16'h8099);
    expect_rec("R6 disp32 imm", 4'd7, 4'h5, 1'b0, 8'h99, 2'd2, 32'h12345678);
    send(16'h0835); expect_rec("R10 ext cleared", 4'd0, 4'h5, 1'b1, 8'h03, 2'd0, 32'h0);
  endtask

  task automatic t_abs;
    send(16'h7F64); send(16'h08A0); expect_rec("R7 abs8", 4'd8, 4'h0, 1'b1, 8'h0A, 2'd0, 32'h00000064);
    send(16'h6A18); send(16'hBEEF); send(16'h8007); expect_rec("R7 abs16", 4'd9, 4'h0, 1'b0, 8'h07, 2'd1, 32'h0000BEEF);
    send(16'h6A38); send(16'hDEAD); send(16'hBEEF); send(16'h0880);
    expect_rec("R7 abs32", 4'd10, 4'h0, 1'b1, 8'h08, 2'd2, 32'hDEADBEEF);
  endtask

  task automatic t_reg_src;
    send(16'h0179); send(16'h8019); expect_rec("R8 postinc", 4'd2, 4'h0, 1'b1, 8'h09, 2'd0, 32'h0);
    send(16'h0179); send(16'hA61C); expect_rec("R8 postdec", 4'd3, 4'h6, 1'b1, 8'h0C, 2'd0, 32'h0);
    send(16'h0179); send(16'h9419); expect_rec("R8 preinc",  4'd4, 4'h4, 1'b1, 8'h09, 2'd0, 32'h0);
    send(16'h0179); send(16'hB315); expect_rec("R8 predec",  4'd5, 4'h3, 1'b1, 8'h05, 2'd0, 32'h0);
    send(16'h0179); send(16'hC21A); send(16'h0001);
    expect_rec("R8 disp16", 4'd6, 4'h2, 1'b1, 8'h0A, 2'd1, 32'h00000001);
    send(16'h0179); send(16'hD819); send(16'hFFFF); send(16'hFFFE);
    expect_rec("R8 disp32", 4'd7, 4'h0, 1'b1, 8'h09, 2'd2, 32'hFFFFFFFE);
  endtask

  task automatic bad_seq(input string tag, input logic [15:0] a, input logic [15:0] b, input logic two);
    if (two) send(a);
    send(b);
    chk({tag, " pulse"}, {62'd0, illegal, out_valid}, 64'b10);
    @(negedge clk);
    chk({tag, " pulse ends"}, {62'd0, illegal, out_valid}, 64'b00);
  endtask

  task automatic t_illegal;
    bad_seq("R9 bad first", 16'h0000, 16'h0000, 1'b0);
    bad_seq("R9 bad auto", 16'h0174, 16'h1234, 1'b1);
    bad_seq("R9 disp16 wrong prefix", 16'h0176, 16'h6E08, 1'b1);
    bad_seq("R9 bad r-mode", 16'h0179, 16'hE019, 1'b1);
    bad_seq("R9 bad r-marker", 16'h0179, 16'h8029, 1'b1);
    bad_seq("R9 bad x78", 16'h7810, 16'h6A18, 1'b1);
    send(16'h8312); expect_rec("R9 recovers", 4'd0, 4'h3, 1'b0, 8'h12, 2'd0, 32'h0);
  endtask

  task automatic t_hold;
    send(16'h0174); send(16'h6E18); send(16'h0042); send(16'h80AA);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 16'h08AB;
    @(negedge clk);
    chk("R1 ready low while pending", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 record held", rec(dst_mode, base_reg, src_is_reg, src_val, ext_words, ext_data),
        rec(4'd6, 4'h1, 1'b0, 8'hAA, 2'd1, 32'h00000042));
    expect_rec("R1 release", 4'd6, 4'h1, 1'b0, 8'hAA, 2'd1, 32'h00000042);
    chk("R1 cleared on accept", {63'd0, out_valid}, 64'd0);
    send(16'h8312); expect_rec("R1 held word not consumed", 4'd0, 4'h3, 1'b0, 8'h12, 2'd0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_auto_imm();
    t_disp_imm();
    t_abs();
    t_reg_src();
    t_illegal();
    t_hold();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule